// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block is a complete shared-bus coherence system for a small cluster of cores (four by default). Each core owns a tiny direct-mapped data cache with one data word per line and a 2-bit coherence state per line. A core presents a read or write on a valid/ready pair and holds it until ready. A round-robin arbiter serialises all requests into single coherence transactions. During a transaction every other cache snoops the target address and moves its matching line through the MESI state table. Dirty data is written back to an on-chip backing memory whenever the table demands it.

Line fills always come from the backing memory. There is no cache-to-cache transfer. A dirty remote copy is therefore written back first and the requester fills afterwards. A dirty victim in the requester's own set is flushed before its replacement arrives, while a clean victim is simply overwritten. The state of every line is exported as a flat vector so that the surrounding system can observe coherence.

Top module: `mesi_coherent_system`

## Requirements
- R1: States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. The state of line l in cache c sits in `lineState[(c*NUM_LINES+l)*2 +: 2]`, and the line index is the low INDEX_W address bits. After reset every line is Invalid, memory reads as zero and no ready is raised.
- R2: A read miss with no other cache holding the address fills from memory, returns the memory value and leaves the requester Exclusive.
- R3: A read miss while another cache holds the address Modified first writes that copy to memory. The requester then fills, and both copies end Shared.
- R4: A read miss while other caches hold the address Shared or Exclusive fills from memory, and the requester and every holder end Shared.
- R5: A write miss makes the requester Modified with the written data and invalidates every other copy. A Modified remote copy is written to memory before that.
- R6: An Exclusive line moves to Modified on a local write without touching other caches. It stays Exclusive on a local read, becomes Shared on a remote read and becomes Invalid on a remote write.
- R7: A Shared line moves to Modified on a local write, and all other copies become Invalid. It stays Shared on local or remote reads and becomes Invalid on a remote write.
- R8: A Modified line stays Modified on local reads and writes. A remote read writes it back and makes it Shared. A remote write writes it back and makes it Invalid.
- R9: An Invalid line, or a line holding another address, keeps its state when other cores read or write.
- R10: Requests are granted round-robin, starting after the last granted core. At most one ready is high in any cycle, and a ready is only raised while that core's valid is high.
- R11: A miss that replaces a Modified line first writes the old data to its own memory address, and a later read of that address returns it. A clean victim is dropped without a memory write.
- R12: Ready appears one cycle after the grant, plus one cycle per write-back (victim flush, snooped flush). A ready is always followed by a cycle without ready.
- R13: Every read returns the most recently written value of its address. For any address, a Modified or Exclusive copy never coexists with another valid copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | Per-core request valid, held until ready |
| reqWrite | input | NUM_CORES | Per-core request type, 1 = write |
| reqAddr | input | NUM_CORES*ADDR_W | Per-core word address, core c at bits c*ADDR_W |
| reqWdata | input | NUM_CORES*DATA_W | Per-core write data, core c at bits c*DATA_W |
| reqReady | output | NUM_CORES | One-cycle completion pulse to the granted core |
| rspRdata | output | DATA_W | Read data, valid while a ready is high |
| lineState | output | NUM_CORES*NUM_LINES*2 | Coherence state of every line (R1 layout) |

## Verification
The hardest situation to create is a read miss whose requester must flush its own dirty victim while another core also holds the target address dirty. In that case two write-backs must run in order before the fill. The bench builds this case directly: two cores write different addresses that map to the same set, and then one of them reads the other's address. A long random phase then keeps all cores on a 32-word space, so that conflicts, upgrades and snooped flushes happen constantly. A four-way simultaneous request shows the rotating grant order.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture the picked request
    logic evictWb;  // flush own dirty victim
    logic snoopWb;  // flush the remote dirty copy
    logic finish;   // apply fill / state update, complete
  } ctlStrobe_t;

endpackage

// File: rtl/mesi_control.sv
module mesi_control #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CORES-1:0]   reqValid,
  input  logic                   victimDirty,
  input  logic                   remoteDirty,
  output mesi_pkg::ctlStrobe_t   strobe,
  output logic [CORE_W-1:0]      pickId,
  output logic [CORE_W-1:0]      grantId,
  output logic [NUM_CORES-1:0]   reqReady
);
  typedef enum logic {CT_IDLE, CT_RUN} ctState_e;

  ctState_e          ctState;
  logic [CORE_W-1:0] lastGrant;
  logic              anyReq;

  // round-robin pick: lowest rotation distance after lastGrant wins
  always_comb begin
    anyReq = 1'b0;
    pickId = lastGrant;
    for (int k = NUM_CORES; k >= 1; k--) begin
      logic [CORE_W-1:0] candId;
      candId = CORE_W'((int'(lastGrant) + k) % NUM_CORES);
      if (reqValid[candId]) begin
        anyReq = 1'b1;
        pickId = candId;
      end
    end
  end

  always_comb begin
    strobe.latch   = (ctState == CT_IDLE) && anyReq;
    strobe.evictWb = (ctState == CT_RUN) && victimDirty;
    strobe.snoopWb = (ctState == CT_RUN) && !victimDirty && remoteDirty;
    strobe.finish  = (ctState == CT_RUN) && !victimDirty && !remoteDirty;
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++)
      reqReady[c] = strobe.finish && (grantId == CORE_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctState   <= CT_IDLE;
      lastGrant <= CORE_W'(NUM_CORES - 1);
      grantId   <= '0;
    end else begin
      case (ctState)
        CT_IDLE: if (anyReq) begin
          grantId   <= pickId;
          lastGrant <= pickId;
          ctState   <= CT_RUN;
        end
        CT_RUN: if (strobe.finish) ctState <= CT_IDLE;
        default: ctState <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_datapath.sv
module mesi_datapath #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int INDEX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  mesi_pkg::ctlStrobe_t            strobe,
  input  logic [CORE_W-1:0]               pickId,
  input  logic [CORE_W-1:0]               grantId,
  input  logic [NUM_CORES-1:0]            reqWrite,
  input  logic [NUM_CORES*ADDR_W-1:0]     reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0]     reqWdata,
  output logic                            victimDirty,
  output logic                            remoteDirty,
  output logic [DATA_W-1:0]               rspRdata,
  output logic [NUM_CORES*(1<<INDEX_W)*2-1:0] lineState
);
  import mesi_pkg::*;

  localparam int NUM_LINES = 1 << INDEX_W;
  localparam int TAG_W     = ADDR_W - INDEX_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  lineSt_e           stArr   [NUM_CORES][NUM_LINES];
  logic [TAG_W-1:0]  tagArr  [NUM_CORES][NUM_LINES];
  logic [DATA_W-1:0] dataArr [NUM_CORES][NUM_LINES];
  logic [DATA_W-1:0] mem     [MEM_DEPTH];

  logic [ADDR_W-1:0] addrIn  [NUM_CORES];
  logic [DATA_W-1:0] wdataIn [NUM_CORES];

  logic [ADDR_W-1:0]  curAddr;
  logic               curWrite;
  logic [DATA_W-1:0]  curWdata;

  logic [INDEX_W-1:0] curIdx;
  logic [TAG_W-1:0]   curTag;
  logic               ownHit;
  logic [ADDR_W-1:0]  victimAddr;
  logic [NUM_CORES-1:0] remHold, remDirty;

  for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_unpack
    assign addrIn[gc]  = reqAddr[gc*ADDR_W +: ADDR_W];
    assign wdataIn[gc] = reqWdata[gc*DATA_W +: DATA_W];
    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_state
      assign lineState[(gc*NUM_LINES+gl)*2 +: 2] = stArr[gc][gl];
    end
  end

  assign curIdx     = curAddr[INDEX_W-1:0];
  assign curTag     = curAddr[ADDR_W-1:INDEX_W];
  assign ownHit     = (stArr[grantId][curIdx] != ST_I) &&
                      (tagArr[grantId][curIdx] == curTag);
  assign victimAddr = {tagArr[grantId][curIdx], curIdx};

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      remHold[c]  = (CORE_W'(c) != grantId) && (stArr[c][curIdx] != ST_I) &&
                    (tagArr[c][curIdx] == curTag);
      remDirty[c] = remHold[c] && (stArr[c][curIdx] == ST_M);
    end
  end

  assign victimDirty = !ownHit && (stArr[grantId][curIdx] == ST_M);
  assign remoteDirty = |remDirty;
  assign rspRdata    = ownHit ? dataArr[grantId][curIdx] : mem[curAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++)
        for (int l = 0; l < NUM_LINES; l++) begin
          stArr[c][l]   <= ST_I;
          tagArr[c][l]  <= '0;
          dataArr[c][l] <= '0;
        end
      for (int a = 0; a < MEM_DEPTH; a++) mem[a] <= '0;
      curAddr  <= '0;
      curWrite <= 1'b0;
      curWdata <= '0;
    end else begin
      if (strobe.latch) begin
        curAddr  <= addrIn[pickId];
        curWrite <= reqWrite[pickId];
        curWdata <= wdataIn[pickId];
      end
      if (strobe.evictWb) begin
        mem[victimAddr]         <= dataArr[grantId][curIdx];
        stArr[grantId][curIdx]  <= ST_I;
      end
      if (strobe.snoopWb) begin
        for (int c = 0; c < NUM_CORES; c++)
          if (remDirty[c]) begin
            mem[curAddr]      <= dataArr[c][curIdx];
            stArr[c][curIdx]  <= curWrite ? ST_I : ST_S;
          end
      end
      if (strobe.finish) begin
        if (curWrite) begin
          for (int c = 0; c < NUM_CORES; c++)
            if (remHold[c]) stArr[c][curIdx] <= ST_I;
          stArr[grantId][curIdx]   <= ST_M;
          tagArr[grantId][curIdx]  <= curTag;
          dataArr[grantId][curIdx] <= curWdata;
        end else if (!ownHit) begin
          for (int c = 0; c < NUM_CORES; c++)
            if (remHold[c]) stArr[c][curIdx] <= ST_S;
          stArr[grantId][curIdx]   <= (|remHold) ? ST_S : ST_E;
          tagArr[grantId][curIdx]  <= curTag;
          dataArr[grantId][curIdx] <= mem[curAddr];
        end
      end
    end
  end
endmodule

// File: rtl/mesi_coherent_system.sv
module mesi_coherent_system #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int INDEX_W   = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_CORES-1:0]                  reqValid,
  input  logic [NUM_CORES-1:0]                  reqWrite,
  input  logic [NUM_CORES*ADDR_W-1:0]           reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0]           reqWdata,
  output logic [NUM_CORES-1:0]                  reqReady,
  output logic [DATA_W-1:0]                     rspRdata,
  output logic [NUM_CORES*(1<<INDEX_W)*2-1:0]   lineState
);
  localparam int NUM_LINES = 1 << INDEX_W;
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  mesi_pkg::ctlStrobe_t strobe;
  logic [CORE_W-1:0]    pickId, grantId;
  logic                 victimDirty, remoteDirty;

  mesi_control #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .victimDirty(victimDirty), .remoteDirty(remoteDirty),
    .strobe(strobe), .pickId(pickId), .grantId(grantId), .reqReady(reqReady)
  );

  mesi_datapath #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
                  .DATA_W(DATA_W), .INDEX_W(INDEX_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pickId(pickId), .grantId(grantId),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .victimDirty(victimDirty), .remoteDirty(remoteDirty),
    .rspRdata(rspRdata), .lineState(lineState)
  );
endmodule

// File: rtl/mesi_checker.sv
module mesi_checker #(
  parameter int NUM_CORES = 4,
  parameter int LINE_BITS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] reqValid,
  input logic [NUM_CORES-1:0] reqReady,
  input logic [LINE_BITS-1:0] lineState
);
  a_r10_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  a_r10_ready_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady & ~reqValid) == '0);

  a_r12_ready_gap: assert property (@(posedge clk) disable iff (!rstN)
    (|reqReady) |=> (reqReady == '0));

  a_r1_reset_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (lineState == '0));

  for (genvar gf = 0; gf < LINE_BITS/2; gf++) begin : g_field
    // R13: a line only becomes valid as the result of a completed request
    a_r13_fill_after_ready: assert property (@(posedge clk) disable iff (!rstN)
      ($past(lineState[gf*2 +: 2]) == 2'd0 && lineState[gf*2 +: 2] != 2'd0)
        |-> $past(|reqReady));
    // R5: entering Modified only happens on a completed write
    a_r5_modified_after_ready: assert property (@(posedge clk) disable iff (!rstN)
      ($past(lineState[gf*2 +: 2]) != 2'd3 && lineState[gf*2 +: 2] == 2'd3)
        |-> $past(|reqReady));
  end
endmodule

bind mesi_coherent_system mesi_checker #(
  .NUM_CORES(NUM_CORES), .LINE_BITS(NUM_CORES*NUM_LINES*2)
) i_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .lineState(lineState)
);

// File: tb/test_mesi_coherent_system.sv
module test_mesi_coherent_system;
  localparam int NC = 4, AW = 5, DW = 8, IW = 2, NL = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NC-1:0]    reqValid = '0, reqWrite = '0, reqReady;
  logic [NC*AW-1:0] reqAddr = '0;
  logic [NC*DW-1:0] reqWdata = '0;
  logic [DW-1:0]    rspRdata;
  logic [NC*NL*2-1:0] lineState;

  int nChecks = 0, nErr = 0;
  int mSt [NC][NL];
  int mTag[NC][NL];
  int refMem[32];

  always #4 clk = ~clk;

  mesi_coherent_system i_mesi_coherent_system (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .lineState(lineState)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stOf(int c, int l);
    return int'(lineState[(c*NL+l)*2 +: 2]);
  endfunction

  // latency from the spec: 1 + own dirty victim + remote dirty copy
  function automatic int expLat(int c, int addr);
    int idx = addr % NL, tg = addr / NL, lat = 1;
    bit hit = (mSt[c][idx] != 0) && (mTag[c][idx] == tg);
    if (!hit && mSt[c][idx] == 3) lat++;
    for (int d = 0; d < NC; d++)
      if (d != c && mSt[d][idx] == 3 && mTag[d][idx] == tg) lat++;
    return lat;
  endfunction

  // MESI table applied to the model
  task automatic applyModel(int c, bit w, int addr, int data);
    int idx = addr % NL, tg = addr / NL;
    bit hit = (mSt[c][idx] != 0) && (mTag[c][idx] == tg);
    bit others = 0;
    for (int d = 0; d < NC; d++)
      if (d != c && mSt[d][idx] != 0 && mTag[d][idx] == tg) begin
        others = 1;
        mSt[d][idx] = w ? 0 : 1;
      end
    if (w) begin
      mSt[c][idx] = 3; mTag[c][idx] = tg; refMem[addr] = data;
    end else if (!hit) begin
      mSt[c][idx] = others ? 1 : 2; mTag[c][idx] = tg;
    end
  endtask

  task automatic compareStates(string req);
    bit ok = 1; int badAct = 0, badExp = 0;
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++)
        if (stOf(c, l) != mSt[c][l]) begin
          ok = 0; badAct = stOf(c, l); badExp = mSt[c][l];
        end
    chk(ok, req, "line states", badAct, badExp);
    // R13 ownership invariant, grouping copies by address
    ok = 1;
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++)
        for (int d = 0; d < NC; d++)
          if (c != d && stOf(c, l) >= 2 && stOf(d, l) != 0 && mTag[c][l] == mTag[d][l])
            ok = 0;
    chk(ok, "R13", "single owner", ok, 1);
  endtask

  task automatic doReq(int c, bit w, int addr, int data, string req);
    int lat = 0, want = expLat(c, addr), expRd = refMem[addr];
    int got;
    @(negedge clk);
    reqValid[c] = 1'b1; reqWrite[c] = w;
    reqAddr[c*AW +: AW] = AW'(addr); reqWdata[c*DW +: DW] = DW'(data);
    do begin @(negedge clk); lat++; end while (!reqReady[c]);
    got = int'(rspRdata);
    chk(lat == want, "R12", "latency", lat, want);
    if (!w) chk(got == expRd, "R13", "read data", got, expRd);
    @(negedge clk);
    reqValid[c] = 1'b0;
    applyModel(c, w, addr, data);
    compareStates(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL R13 watchdog: actual hung expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    int order[$];
    bit drop[NC];
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++) begin mSt[c][l] = 0; mTag[c][l] = 0; end
    for (int a = 0; a < 32; a++) refMem[a] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(lineState == '0, "R1", "reset states", int'(lineState != '0), 0);
    chk(reqReady == '0, "R1", "reset ready", int'(reqReady), 0);

    doReq(0, 0, 5, 0, "R2");          // miss, nobody holds -> E
    chk(stOf(0, 1) == 2, "R2", "exclusive after lone fill", stOf(0, 1), 2);
    doReq(0, 0, 5, 0, "R6");          // E local read stays E
    doReq(0, 1, 5, 8'hA1, "R6");      // E local write -> M silently
    doReq(0, 0, 5, 0, "R8");          // M local read stays M
    doReq(0, 1, 5, 8'hA2, "R8");      // M local write stays M
    doReq(1, 0, 5, 0, "R3");          // remote M flushed, both S
    chk(stOf(0, 1) == 1 && stOf(1, 1) == 1, "R3", "both shared", stOf(0, 1), 1);
    doReq(2, 0, 5, 0, "R4");          // holders in S -> three S
    doReq(1, 0, 5, 0, "R7");          // S local read stays S
    doReq(2, 1, 5, 8'hB2, "R7");      // S local write -> M, others I
    chk(stOf(0, 1) == 0 && stOf(1, 1) == 0, "R7", "others invalid", stOf(0, 1), 0);
    doReq(3, 1, 5, 8'hC3, "R5");      // write miss, remote M flushed then I
    chk(stOf(2, 1) == 0 && stOf(3, 1) == 3, "R8", "remote write on M", stOf(2, 1), 0);
    doReq(2, 0, 2, 0, "R2");          // core2 E on addr2
    doReq(3, 0, 2, 0, "R6");          // remote read on E -> S, R4 too
    chk(stOf(2, 2) == 1, "R6", "E to S on remote read", stOf(2, 2), 1);
    doReq(0, 0, 9, 0, "R2");
    doReq(1, 1, 9, 8'h19, "R6");      // remote write on E -> I
    chk(stOf(0, 1) == 0, "R6", "E to I on remote write", stOf(0, 1), 0);
    doReq(2, 0, 9, 0, "R9");          // core0 invalid line ignores remote read
    chk(stOf(0, 1) == 0, "R9", "invalid ignores remote read", stOf(0, 1), 0);
    doReq(0, 0, 13, 0, "R9");         // other tag in core3 (addr5 M) untouched
    chk(stOf(3, 1) == 3, "R9", "other address untouched", stOf(3, 1), 3);
    doReq(3, 0, 1, 0, "R11");         // core3 evicts dirty addr5
    doReq(1, 0, 5, 0, "R11");         // must read C3 from memory
    doReq(0, 0, 17, 0, "R11");        // clean victim addr13 dropped
    doReq(0, 1, 6, 8'h66, "R11");
    doReq(1, 1, 10, 8'hAA, "R11");
    doReq(0, 0, 10, 0, "R3");         // own dirty victim + remote dirty: latency 3
    doReq(2, 0, 6, 0, "R11");         // flushed victim value visible

    // R10 round robin: last grant was core2 -> order 3,0,1,2
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      reqValid[c] = 1'b1; reqWrite[c] = 1'b0;
      reqAddr[c*AW +: AW] = AW'(16 + c); drop[c] = 0;
    end
    while (order.size() < NC) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) if (drop[c]) begin reqValid[c] = 1'b0; drop[c] = 0; end
      for (int c = 0; c < NC; c++)
        if (reqReady[c]) begin
          chk(int'(rspRdata) == refMem[16 + c], "R13", "arbitrated read", int'(rspRdata), refMem[16 + c]);
          applyModel(c, 0, 16 + c, 0);
          order.push_back(c);
          drop[c] = 1;
        end
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) if (drop[c]) reqValid[c] = 1'b0;
    for (int k = 0; k < NC; k++)
      chk(order[k] == (3 + k) % NC, "R10", "grant order", order[k], (3 + k) % NC);
    compareStates("R10");

    // random coherence traffic over the whole 32-word space
    for (int n = 0; n < 500; n++) begin
      int c = $urandom_range(0, NC - 1);
      bit w = 1'($urandom_range(0, 1));
      int a = $urandom_range(0, 31);
      doReq(c, w, a, int'($urandom_range(0, 255)), "R13");
    end

    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule